// File: doc/BRIEF.md
# Three-Bit Signed Adder/Subtracter with Extended Result

This block is a combinational arithmetic unit for two 3-bit two's-complement operands, X and Y. A single mode pin chooses the operation: when it is low the unit forms Y + X, and when it is high it forms Y - X. To subtract, it inverts each bit of X and sets the carry into the lowest slice to one.

The result is always 4 bits wide and always exact. The three low bits come from a ripple chain of full-adder slices. A fourth, sum-only slice adds the sign-extended top bits of both operands together with the carry out of the chain. A flag reports whether the result would fit in 3 bits, so a user can keep the short form when it is valid and fall back to the wide form otherwise. No clock or register appears anywhere in the path.

Top module: `sa_addsub3`

## Requirements
- R1: With `sub_mode` = 0, `res` equals the 4-bit two's-complement value of sext(X) + sext(Y), where sext copies bit 2 into bit 3.
- R2: With `sub_mode` = 1, `res` equals the 4-bit two's-complement value of sext(Y) - sext(X).
- R3: `ovf` is 1 exactly when the integer result of R1 or R2 is below -4 or above +3.
- R4: `ovf` is 1 exactly when `res[3]` and `res[2]` differ.
- R5: `res[2:0]` equals the integer result taken modulo 8, so read as unsigned it wraps. For example, 111 + 001 gives 000.
- R6: Subtracting X = 100 (-4) stays exact. With Y = 000 the result is 0100 (+4) with `ovf` = 1.
- R7: Y = -3 minus X = +2 gives 1011 (-5) with `ovf` = 1. Y = -3 plus X = -1 gives 1100 (-4) with `ovf` = 0.
- R8: -1 plus +1 gives 0000 with `ovf` = 0.
- R9: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 3 | Operand X, two's complement; this operand is negated in subtract mode |
| op_y | input | 3 | Operand Y, two's complement |
| sub_mode | input | 1 | 0 selects Y + X, 1 selects Y - X |
| res | output | 4 | Exact sign-extended result |
| ovf | output | 1 | 1 when the result does not fit in 3 bits |

## Verification
The hardest case to reach is negating -4. Inverting 100 and adding one wraps back to 100 within 3 bits, and only the extended slice recovers +4. The stimulus goes there directly: X = 100 in subtract mode against every Y. A full sweep of all 128 operand and mode combinations then catches any carry path that is right for some patterns and wrong for others. To show that no state is held, the bench applies a vector, then a different one, then the first again, and checks that the outputs return to the first values.

// File: rtl/sa_addsub_pkg.sv
package sa_addsub_pkg;
  localparam int OPW  = 3;
  localparam int RESW = OPW + 1;
  localparam int MSB  = OPW - 1;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } mode_e;
endpackage

// File: rtl/sa_inv_ctl.sv
module sa_inv_ctl #(
  parameter int W = 3
) (
  input  logic [W-1:0] din,
  input  logic         inv,
  output logic [W-1:0] dout
);
  // One XOR per bit: the bit is passed through or inverted under control
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ inv;
  end
endmodule

// File: rtl/sa_fa_slice.sv
module sa_fa_slice (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/sa_sign_slice.sv
module sa_sign_slice (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s
);
  // Extended sign bit: the carry out would be dropped, so only the sum is formed
  assign s = a ^ b ^ ci;
endmodule

// File: rtl/sa_addsub3.sv
module sa_addsub3
  import sa_addsub_pkg::*;
(
  input  logic [OPW-1:0]  op_x,
  input  logic [OPW-1:0]  op_y,
  input  logic            sub_mode,
  output logic [RESW-1:0] res,
  output logic            ovf
);
  logic [OPW-1:0] x_mod;
  logic [OPW:0]   carry;

  sa_inv_ctl #(.W(OPW)) u_inv (
    .din  (op_x),
    .inv  (sub_mode),
    .dout (x_mod)
  );

  // The mode bit is also the carry into the lowest slice; in subtract mode this adds the +1
  assign carry[0] = sub_mode;

  for (genvar i = 0; i < OPW; i++) begin : g_slice
    sa_fa_slice u_fa (
      .a  (x_mod[i]),
      .b  (op_y[i]),
      .ci (carry[i]),
      .s  (res[i]),
      .co (carry[i+1])
    );
  end

  // The top slice repeats the sign-bit addition on the sign-extended operands
  sa_sign_slice u_sign (
    .a  (x_mod[MSB]),
    .b  (op_y[MSB]),
    .ci (carry[OPW]),
    .s  (res[OPW])
  );

  assign ovf = res[OPW] ^ res[MSB];
endmodule

// File: rtl/sa_addsub3_chk.sv
module sa_addsub3_chk
  import sa_addsub_pkg::*;
(
  input logic [OPW-1:0]  op_x,
  input logic [OPW-1:0]  op_y,
  input logic            sub_mode,
  input logic [RESW-1:0] res,
  input logic            ovf
);
  int vx, vy, vr, vres;

  always_comb begin
    vx   = int'($signed(op_x));
    vy   = int'($signed(op_y));
    vr   = sub_mode ? (vy - vx) : (vy + vx);
    vres = int'($signed(res));
  end

  always_comb begin
    // R1
    p_add_exact_r1: assert final (sub_mode || vres == vr);
    // R2
    p_sub_exact_r2: assert final (!sub_mode || vres == vr);
    // R3
    p_ovf_range_r3: assert final (ovf == ((vr < -4) || (vr > 3)));
    // R4
    p_ovf_top_bits_r4: assert final (ovf == (res[3] != res[2]));
    // R5
    p_trunc_r5: assert final (res[2:0] == 3'(vr));
  end
endmodule

bind sa_addsub3 sa_addsub3_chk u_chk (
  .op_x     (op_x),
  .op_y     (op_y),
  .sub_mode (sub_mode),
  .res      (res),
  .ovf      (ovf)
);

// File: tb/sa_addsub3_tb_top.sv
module sa_addsub3_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_x = '0;
  logic [2:0] op_y = '0;
  logic       sub_mode = 1'b0;
  logic [3:0] res;
  logic       ovf;
  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sa_addsub3 dut_i (
    .op_x(op_x), .op_y(op_y), .sub_mode(sub_mode), .res(res), .ovf(ovf)
  );

  task automatic chk(input string req, input logic [3:0] er, input logic eo);
    checks++;
    if (res !== er || ovf !== eo) begin
      fails++;
      $display("FAIL %s x=%b y=%b sub=%b res=%b ovf=%b expected res=%b ovf=%b",
               req, op_x, op_y, sub_mode, res, ovf, er, eo);
    end
  endtask

  task automatic apply(input logic [2:0] x, input logic [2:0] y, input logic m);
    @(negedge clk);
    op_x = x; op_y = y; sub_mode = m;
    #1;
  endtask

  function automatic int sx3(input logic [2:0] v);
    return v[2] ? int'(v) - 8 : int'(v);
  endfunction

  task automatic t_idle_zero();
    apply(3'b000, 3'b000, 1'b0);
    chk("R1 zero", 4'b0000, 1'b0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 8; x++)
        for (int y = 0; y < 8; y++) begin
          int r;
          apply(3'(x), 3'(y), 1'(m));
          r = (m == 1) ? sx3(3'(y)) - sx3(3'(x)) : sx3(3'(y)) + sx3(3'(x));
          chk(m == 1 ? "R2 R3 sweep" : "R1 R3 sweep", 4'(r), (r < -4) || (r > 3));
          checks++;
          if (res[2:0] !== 3'(r) || ovf !== (res[3] != res[2])) begin
            fails++;
            $display("FAIL R4 R5 res=%b ovf=%b expected low=%b", res, ovf, 3'(r));
          end
        end
  endtask

  task automatic t_neg_min();
    apply(3'b100, 3'b000, 1'b1);
    chk("R6 0-(-4)", 4'b0100, 1'b1);
    apply(3'b100, 3'b011, 1'b1);
    chk("R6 3-(-4)", 4'b0111, 1'b1);
    apply(3'b100, 3'b100, 1'b1);
    chk("R6 -4-(-4)", 4'b0000, 1'b0);
  endtask

  task automatic t_examples();
    apply(3'b010, 3'b101, 1'b1);
    chk("R7 -3-2", 4'b1011, 1'b1);
    apply(3'b111, 3'b101, 1'b0);
    chk("R7 -3+-1", 4'b1100, 1'b0);
    apply(3'b001, 3'b111, 1'b0);
    chk("R8 -1+1", 4'b0000, 1'b0);
    apply(3'b010, 3'b010, 1'b0);
    chk("R3 2+2", 4'b0100, 1'b1);
  endtask

  task automatic t_no_state();
    apply(3'b011, 3'b011, 1'b0);
    chk("R9 first", 4'b0110, 1'b1);
    apply(3'b100, 3'b100, 1'b0);
    chk("R9 other", 4'b1000, 1'b1);
    apply(3'b011, 3'b011, 1'b0);
    chk("R9 repeat", 4'b0110, 1'b1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle_zero();
    t_sweep();
    t_neg_min();
    t_examples();
    t_no_state();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule